// File: doc/BRIEF.md
# AC-Synchronized Motor Speed Controller

This block controls a universal motor on mains power with four selectable speeds. Each mains half-cycle starts with a one-cycle zero-crossing pulse. At that pulse the block reads the two-bit speed switch and loads a firing delay, measured in control ticks. When the delay runs out, the block turns the drive gate on. The gate stays on until the next zero crossing. A longer delay gives less power to the winding. Because power changes happen only at fixed points inside each half-cycle, the line sees no sudden power steps in the middle of a half-cycle.

The analog front end supplies two digital flags: one for excessive current (stall) and one for overtemperature. Either flag turns the gate off at once and latches a fault. While a fault is latched, the gate stays dark and the matching lamp is lit. The fault clears when the switch is moved to the lowest speed with the flag low, or on reset. The gate fires again only from the next zero crossing after the fault clears. A power lamp shows that the mains is present, meaning at least one zero crossing has been seen since reset.

The control tick is about 166 µs, so roughly fifty ticks fit in a 60 Hz half-cycle.

Top module: `acsync_speed_ctrl`

## Requirements
- R1: While reset is held, the gate and all three lamps are low. After reset, the gate stays low and the power lamp stays off, whatever the ticks do, until a zero-crossing pulse is sampled. The power lamp lights one clock after the first sampled zero crossing.
- R2: The speed code is 0 to 3. Code 0 is the lowest power and code 3 the highest. Code m maps to a delay of BASE_TICKS + (3 − m)·STEP_TICKS ticks, which is 38, 28, 18 and 8 with the defaults. The gate rises one clock after the edge that samples the delay-th tick following the zero crossing.
- R3: Once on, the gate stays high until the next zero-crossing pulse. It is low one clock after that pulse is sampled. If a crossing arrives before the delay has expired, the gate does not turn on in that half-cycle.
- R4: The speed code is captured only at the zero crossing. Moving the switch during a half-cycle does not change that half-cycle's delay.
- R5: A high stall flag or overtemperature flag drives the gate low one clock after it is sampled. In that same clock, the overload lamp (for stall) or the temperature lamp (for overtemperature) lights.
- R6: A fault stays latched, with its lamp lit and no gate pulse in later half-cycles, until a clock samples the switch at code 0 with that fault's flag low. While the flag is still high, it keeps the fault set even when the switch is at code 0.
- R7: After a fault clears in the middle of a half-cycle, the gate stays low for the rest of that half-cycle. Firing resumes from the next zero crossing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| zcPulse | input | 1 | One-clock pulse at each mains zero crossing |
| tickPulse | input | 1 | One-clock control tick strobe |
| speedSel | input | MODE_W | Speed switch code, 0 = lowest power |
| stallFlag | input | 1 | Excessive motor current detected |
| hotFlag | input | 1 | Winding overtemperature detected |
| gateOut | output | 1 | Drive enable to the gate driver |
| lampPower | output | 1 | Mains present / controller synchronized |
| lampOverload | output | 1 | Stall fault latched |
| lampHot | output | 1 | Overtemperature fault latched |

## Verification
Every result is registered, and each one is due a fixed number of clocks after its stimulus:
- A gate rise comes one clock after the edge that samples the delay-th tick following the crossing.
- A gate fall comes one clock after the edge that samples a crossing or a fault flag.
- A lamp changes one clock after the edge that samples the flag, the crossing or the switch.

The bench drives inputs on falling edges and tracks the rising edges with its own cycle count. For every half-cycle that should fire, the driver records the exact cycle of the expected gate rise. The monitor compares each observed rise with that cycle, so the delay is held to the exact tick. The driver checks the level-type results at the first falling edge after the deciding rising edge.

// File: rtl/acsync_pkg.sv
package acsync_pkg;

  // Strobes from the control module to the counting datapath.
  typedef struct packed {
    logic load;   // start of half-cycle: capture speed, reload counter
    logic step;   // count one control tick down
    logic fire;   // turn the gate on
    logic kill;   // force the gate off
  } dpStrobe_t;

  // Firing delay for a speed code: the highest code gets the shortest delay.
  function automatic int unsigned modeDelay(input int unsigned mode,
                                            input int unsigned baseTicks,
                                            input int unsigned stepTicks,
                                            input int unsigned numModes);
    return baseTicks + (numModes - 1 - mode) * stepTicks;
  endfunction

endpackage

// File: rtl/acsync_datapath.sv
module acsync_datapath
  import acsync_pkg::*;
#(
  parameter int MODE_W     = 2,
  parameter int CNT_W      = 6,
  parameter int BASE_TICKS = 8,
  parameter int STEP_TICKS = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [MODE_W-1:0] speedSel,
  output logic              cntLast,
  output logic              cntIdle,
  output logic              gateOut
);

  localparam int NMODES = 1 << MODE_W;

  logic [CNT_W-1:0] delayTab [NMODES];
  logic [CNT_W-1:0] tickCnt;
  logic             gateReg;

  // One table entry per speed code, computed from the parameters.
  for (genvar g = 0; g < NMODES; g++) begin : gDelay
    assign delayTab[g] = CNT_W'(modeDelay(g, BASE_TICKS, STEP_TICKS, NMODES));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tickCnt <= '0;
    end else if (strobe.load) begin
      tickCnt <= delayTab[speedSel];
    end else if (strobe.step) begin
      tickCnt <= tickCnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gateReg <= 1'b0;
    end else if (strobe.kill) begin
      gateReg <= 1'b0;
    end else if (strobe.fire) begin
      gateReg <= 1'b1;
    end
  end

  assign cntLast = (tickCnt == CNT_W'(1));
  assign cntIdle = (tickCnt == '0);
  assign gateOut = gateReg;

endmodule

// File: rtl/acsync_ctrl.sv
module acsync_ctrl
  import acsync_pkg::*;
#(
  parameter int MODE_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              zcPulse,
  input  logic              tickPulse,
  input  logic [MODE_W-1:0] speedSel,
  input  logic              stallFlag,
  input  logic              hotFlag,
  input  logic              cntLast,
  input  logic              cntIdle,
  output dpStrobe_t         strobe,
  output logic              lampPower,
  output logic              lampOverload,
  output logic              lampHot
);

  logic synced;
  logic armed;
  logic ovlFault, hotFault;
  logic ovlNext, hotNext;
  logic faultNext;
  logic clearReq;
  logic tickOnly;

  // Moving the switch to the lowest code releases a fault whose flag is gone.
  assign clearReq  = (speedSel == '0);
  assign ovlNext   = stallFlag | (ovlFault & ~clearReq);
  assign hotNext   = hotFlag   | (hotFault & ~clearReq);
  assign faultNext = ovlNext | hotNext;

  // A tick that lands on a crossing is absorbed by the reload.
  assign tickOnly = tickPulse & ~zcPulse;

  always_comb begin
    strobe.load = zcPulse;
    strobe.step = tickOnly & ~cntIdle;
    strobe.fire = tickOnly & cntLast & armed & ~faultNext;
    strobe.kill = zcPulse | faultNext;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      synced   <= 1'b0;
      armed    <= 1'b0;
      ovlFault <= 1'b0;
      hotFault <= 1'b0;
    end else begin
      ovlFault <= ovlNext;
      hotFault <= hotNext;
      if (zcPulse) begin
        synced <= 1'b1;
      end
      // Arming happens only at a crossing; a fault disarms at once.
      if (faultNext) begin
        armed <= 1'b0;
      end else if (zcPulse) begin
        armed <= 1'b1;
      end
    end
  end

  assign lampPower    = synced;
  assign lampOverload = ovlFault;
  assign lampHot      = hotFault;

endmodule

// File: rtl/acsync_speed_ctrl.sv
module acsync_speed_ctrl
  import acsync_pkg::*;
#(
  parameter int MODE_W     = 2,
  parameter int CNT_W      = 6,
  parameter int BASE_TICKS = 8,
  parameter int STEP_TICKS = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              zcPulse,
  input  logic              tickPulse,
  input  logic [MODE_W-1:0] speedSel,
  input  logic              stallFlag,
  input  logic              hotFlag,
  output logic              gateOut,
  output logic              lampPower,
  output logic              lampOverload,
  output logic              lampHot
);

  dpStrobe_t strobe;
  logic      cntLast;
  logic      cntIdle;

  acsync_ctrl #(
    .MODE_W(MODE_W)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .zcPulse     (zcPulse),
    .tickPulse   (tickPulse),
    .speedSel    (speedSel),
    .stallFlag   (stallFlag),
    .hotFlag     (hotFlag),
    .cntLast     (cntLast),
    .cntIdle     (cntIdle),
    .strobe      (strobe),
    .lampPower   (lampPower),
    .lampOverload(lampOverload),
    .lampHot     (lampHot)
  );

  acsync_datapath #(
    .MODE_W    (MODE_W),
    .CNT_W     (CNT_W),
    .BASE_TICKS(BASE_TICKS),
    .STEP_TICKS(STEP_TICKS)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .speedSel(speedSel),
    .cntLast (cntLast),
    .cntIdle (cntIdle),
    .gateOut (gateOut)
  );

endmodule

// File: rtl/acsync_checker.sv
module acsync_checker #(
  parameter int MODE_W = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              zcPulse,
  input logic              tickPulse,
  input logic [MODE_W-1:0] speedSel,
  input logic              stallFlag,
  input logic              hotFlag,
  input logic              gateOut,
  input logic              lampPower,
  input logic              lampOverload,
  input logic              lampHot
);

  AST_NO_GATE_UNSYNCED: assert property (@(posedge clk) disable iff (!rstN)
    !lampPower |-> !gateOut); // R1

  AST_RISE_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
    $rose(gateOut) |-> $past(tickPulse)); // R2

  AST_ZC_DROPS_GATE: assert property (@(posedge clk) disable iff (!rstN)
    zcPulse |=> !gateOut); // R3

  AST_STALL_KILLS: assert property (@(posedge clk) disable iff (!rstN)
    stallFlag |=> (!gateOut && lampOverload)); // R5

  AST_HOT_KILLS: assert property (@(posedge clk) disable iff (!rstN)
    hotFlag |=> (!gateOut && lampHot)); // R5

  AST_NO_GATE_IN_FAULT: assert property (@(posedge clk) disable iff (!rstN)
    (lampOverload || lampHot) |-> !gateOut); // R6

  AST_OVL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (lampOverload && speedSel != '0) |=> lampOverload); // R6

  AST_HOT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (lampHot && speedSel != '0) |=> lampHot); // R6

endmodule

bind acsync_speed_ctrl acsync_checker #(.MODE_W(MODE_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .zcPulse     (zcPulse),
  .tickPulse   (tickPulse),
  .speedSel    (speedSel),
  .stallFlag   (stallFlag),
  .hotFlag     (hotFlag),
  .gateOut     (gateOut),
  .lampPower   (lampPower),
  .lampOverload(lampOverload),
  .lampHot     (lampHot)
);

// File: tb/acsync_speed_ctrl_bench.sv
module acsync_speed_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int TD         = 4;   // clocks per control tick
  localparam int BASE       = 8;
  localparam int STEP       = 10;

  logic       clk = 1'b0;
  logic       rstN;
  logic       zcPulse;
  logic       tickPulse;
  logic [1:0] speedSel;
  logic       stallFlag;
  logic       hotFlag;
  logic       gateOut;
  logic       lampPower;
  logic       lampOverload;
  logic       lampHot;

  int nRun  = 0;
  int nFail = 0;
  int cyc   = 0;

  // Scoreboard: expected gate-rise cycles and their requirement tags.
  int    expCyc[$];
  string expReq[$];

  bit modelFault = 1'b0;
  bit modelArmed = 1'b0;
  bit gatePrev   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  acsync_speed_ctrl u_acsync_speed_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .zcPulse     (zcPulse),
    .tickPulse   (tickPulse),
    .speedSel    (speedSel),
    .stallFlag   (stallFlag),
    .hotFlag     (hotFlag),
    .gateOut     (gateOut),
    .lampPower   (lampPower),
    .lampOverload(lampOverload),
    .lampHot     (lampHot)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Monitor: every gate rise must match the head of the scoreboard.
  always @(negedge clk) begin
    if (!rstN) begin
      gatePrev = 1'b0;
    end else begin
      if (gateOut && !gatePrev) begin
        if (expCyc.size() == 0) begin
          check(1'b0, "R3 unexpected gate pulse", cyc, -1);
        end else begin
          int    e;
          string r;
          e = expCyc.pop_front();
          r = expReq.pop_front();
          check(cyc == e, r, cyc, e);
        end
      end
      gatePrev = gateOut;
    end
  end

  task automatic ticksOnly(input int n);
    for (int i = 0; i < n; i++) begin
      repeat (TD - 1) @(negedge clk);
      tickPulse = 1'b1;
      @(negedge clk);
      tickPulse = 1'b0;
    end
  endtask

  // One mains half-cycle: crossing, then nTicks ticks, optional switch move
  // at the first tick, optional fault flag at tick faultTick.
  task automatic runHalf(input int mode, input int nTicks, input int midMode,
                         input int faultTick, input bit faultHot, input string req);
    int k;
    int d;
    bit fires;
    @(negedge clk);
    speedSel = 2'(mode);
    zcPulse  = 1'b1;
    k = cyc + 1;
    if (mode == 0) modelFault = 1'b0;
    modelArmed = !modelFault;
    d = BASE + (3 - mode) * STEP;
    fires = modelArmed && (d <= nTicks) && (faultTick == 0 || faultTick > d);
    if (fires) begin
      expCyc.push_back(k + d * TD);
      expReq.push_back(req);
    end
    @(negedge clk);
    zcPulse = 1'b0;
    check(gateOut == 1'b0, "R3 gate low after crossing", int'(gateOut), 0);
    for (int n = 1; n <= nTicks; n++) begin
      repeat (TD - 1) @(negedge clk);
      tickPulse = 1'b1;
      if (n == 1 && midMode >= 0) begin
        speedSel = 2'(midMode);
        if (midMode == 0) modelFault = 1'b0;
      end
      if (n == faultTick) begin
        if (faultHot) hotFlag = 1'b1;
        else          stallFlag = 1'b1;
      end
      @(negedge clk);
      tickPulse = 1'b0;
      if (n == faultTick) begin
        stallFlag  = 1'b0;
        hotFlag    = 1'b0;
        modelFault = 1'b1;
        modelArmed = 1'b0;
        check(gateOut == 1'b0, "R5 gate off on fault", int'(gateOut), 0);
        if (faultHot) check(lampHot == 1'b1, "R5 hot lamp", int'(lampHot), 1);
        else          check(lampOverload == 1'b1, "R5 overload lamp", int'(lampOverload), 1);
      end
    end
    if (fires && faultTick == 0)
      check(gateOut == 1'b1, "R3 gate held to crossing", int'(gateOut), 1);
    else
      check(gateOut == 1'b0, req, int'(gateOut), 0);
  endtask

  initial begin
    rstN      = 1'b0;
    zcPulse   = 1'b0;
    tickPulse = 1'b0;
    speedSel  = 2'd2;
    stallFlag = 1'b0;
    hotFlag   = 1'b0;
    repeat (5) @(negedge clk);
    check(gateOut == 1'b0, "R1 reset gate", int'(gateOut), 0);
    check(lampPower == 1'b0, "R1 reset power lamp", int'(lampPower), 0);
    check(lampOverload == 1'b0 && lampHot == 1'b0, "R1 reset fault lamps",
          int'(lampOverload) + int'(lampHot), 0);
    rstN = 1'b1;

    // R1: ticks without any crossing never fire.
    ticksOnly(50);
    check(gateOut == 1'b0, "R1 no gate before sync", int'(gateOut), 0);
    check(lampPower == 1'b0, "R1 power lamp before sync", int'(lampPower), 0);

    runHalf(3, 60, -1, 0, 1'b0, "R1 first half fires");
    check(lampPower == 1'b1, "R1 power lamp after sync", int'(lampPower), 1);

    // R2: each speed code's delay.
    runHalf(2, 60, -1, 0, 1'b0, "R2 code 2 delay");
    runHalf(1, 60, -1, 0, 1'b0, "R2 code 1 delay");
    runHalf(0, 60, -1, 0, 1'b0, "R2 code 0 delay");
    runHalf(3, 60, -1, 0, 1'b0, "R2 code 3 delay");

    // R4: switch moved mid half-cycle keeps the captured code.
    runHalf(1, 60, 3, 0, 1'b0, "R4 captured code kept");
    runHalf(3, 60, -1, 0, 1'b0, "R4 new code at next crossing");

    // R3: crossing before the delay expires means no pulse.
    runHalf(0, 30, -1, 0, 1'b0, "R3 short half no pulse");

    // R5/R6: stall after firing, then latched.
    runHalf(3, 60, -1, 20, 1'b0, "R5 fire before stall");
    runHalf(3, 60, -1, 0, 1'b0, "R6 latched stall blocks");
    check(lampOverload == 1'b1, "R6 overload lamp held", int'(lampOverload), 1);

    // R7: clear mid-half, no pulse until the next crossing.
    runHalf(2, 60, 0, 0, 1'b0, "R7 no pulse after mid clear");
    check(lampOverload == 1'b0, "R6 overload cleared by code 0", int'(lampOverload), 0);
    runHalf(2, 60, -1, 0, 1'b0, "R7 resumes at crossing");

    // R5: overtemperature before the delay expires.
    runHalf(2, 60, -1, 5, 1'b1, "R5 hot blocks pulse");
    runHalf(1, 60, -1, 0, 1'b0, "R6 latched hot blocks");

    // R6: a flag still high wins over code 0.
    @(negedge clk);
    hotFlag  = 1'b1;
    speedSel = 2'd0;
    repeat (3) @(negedge clk);
    check(lampHot == 1'b1, "R6 hot kept while flag high", int'(lampHot), 1);
    check(gateOut == 1'b0, "R5 gate low while hot", int'(gateOut), 0);
    hotFlag = 1'b0;
    @(negedge clk);
    check(lampHot == 1'b0, "R6 hot cleared when flag drops", int'(lampHot), 0);
    modelFault = 1'b0;

    runHalf(1, 60, -1, 0, 1'b0, "R2 code 1 after recovery");
    @(negedge clk);
    zcPulse = 1'b1;
    @(negedge clk);
    zcPulse = 1'b0;
    check(gateOut == 1'b0, "R3 final crossing drops gate", int'(gateOut), 0);

    while (expCyc.size() != 0) begin
      int    e;
      string r;
      e = expCyc.pop_front();
      r = expReq.pop_front();
      check(1'b0, r, -1, e);
    end

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nRun++;
    nFail++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule